// File: doc/BRIEF.md
# Integer Instruction Decoder

This block is a purely combinational decoder for a 32-bit load/store integer instruction set of the classic three-register-field kind. A fetched instruction word goes in. A decoded record comes out, with these fields:

- the instruction class
- the ALU operation and the branch comparison kind
- the two source register indices and the destination index
- a fully extended immediate and a flag that says whether the immediate replaces the second ALU operand
- flags for memory access, register write-back and control transfer
- a write-back source selector

An execute stage consumes this record directly. It needs no further knowledge of opcode bit layouts.

The supported subset is listed below:

- **Register-register ALU** (primary opcode 0x00), selected by the function code: 0x21 add, 0x23 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A set-less-than, 0x2B set-less-than-unsigned.
- **Register jumps** (primary opcode 0x00): function 0x08 is a register jump and function 0x09 is a register jump with link.
- **Immediate ALU**: 0x09 add, 0x0A set-less-than, 0x0B set-less-than-unsigned, 0x0C and, 0x0D or, 0x0E xor.
- **Memory**: load word 0x23 and store word 0x2B.
- **Two-register branches**: 0x04 equal and 0x05 not-equal.
- **Branches against zero**: 0x06 less-or-equal and 0x07 greater.
- **Zero-compare group** (opcode 0x01): field 20:16 value 0 means less-than-zero and value 1 means greater-or-equal-zero.
- **Absolute jumps**: 0x02 jump and 0x03 jump-and-link.

Top module: `smx_decode`

## Requirements
- R1: The class output uses this encoding: 0 ALU, 1 load, 2 store, 3 branch, 4 jump, 5 register jump, 6 jump-and-link, 7 register jump-and-link, 8 illegal. The class is decided by the primary opcode in bits 31:26, and for opcode 0x01 also by bits 20:16, as in the table above.
- R2: ALU operation codes are 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 slt, 7 sltu. For opcode 0x00, function bits 5:0 pick the operation. For immediate ALU ops the opcode picks it. Every non-ALU class reports 0. A function code outside the supported list yields class 8.
- R3: `rs1_idx` always equals bits 25:21 and `rs2_idx` always equals bits 20:16, for every word including illegal ones.
- R4: `rd_idx` takes its value by class:
  - bits 20:16 for immediate ALU ops and loads
  - bits 15:11 for register-register ALU ops
  - 31 for both link classes, whatever bits 15:11 hold
  - 0 otherwise
- R5: For signed immediate ALU ops (0x09, 0x0A, 0x0B), loads, stores and branches, `imm` is bits 15:0 sign-extended to 32 bits. For 0x0C, 0x0D and 0x0E it is bits 15:0 zero-extended.
- R6: For jump and jump-and-link, `imm` is bits 25:0 shifted left by two and zero-extended (bits 31:28 are zero). For register jumps and illegal words `imm` is 0.
- R7: `imm_valid` is 1 exactly for immediate ALU ops, loads and stores.
- R8: `reg_wr` is 1 exactly for classes ALU, load, jump-and-link and register jump-and-link.
- R9: `mem_op` is 1 exactly for loads and stores. `ctrl_xfer` is 1 exactly for branch, jump, register jump and both link classes.
- R10: Branch compare codes are 0 none, 1 equal, 2 not-equal, 3 less-than-zero, 4 less-or-equal-zero, 5 greater-than-zero, 6 greater-or-equal-zero. Non-branch classes report 0.
- R11: `wb_sel` is 2 (return address) for the link classes, 1 (memory data) for loads, and 0 (ALU result) for every other class.
- R12: An illegal word has `reg_wr`, `mem_op`, `ctrl_xfer` and `imm_valid` all at 0, and `imm`, `rd_idx`, `alu_fn`, `br_cmp` and `wb_sel` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| iclass | output | 4 | Instruction class code |
| alu_fn | output | 3 | ALU operation code |
| br_cmp | output | 3 | Branch comparison kind |
| rs1_idx | output | REG_W | First source register index |
| rs2_idx | output | REG_W | Second source register index |
| rd_idx | output | REG_W | Destination register index |
| imm | output | XLEN | Extended immediate |
| imm_valid | output | 1 | Immediate replaces second operand |
| reg_wr | output | 1 | Instruction writes a register |
| mem_op | output | 1 | Instruction accesses memory |
| ctrl_xfer | output | 1 | Instruction may redirect the program counter |
| wb_sel | output | 2 | Write-back data source |

## Verification
The two functions that meet in one decode are control transfer and register write-back. Both link classes raise `ctrl_xfer` and `reg_wr` together, and they also force the destination to 31 and pick the return address for write-back. The bench provokes this with link words whose bits 15:11 hold a nonzero index, and it judges that the forced destination wins over the field while both flags stay high. The random mix places such words next to plain jumps and register ALU ops that share the same opcode, so that neither function leaks into its neighbour.

// File: rtl/smx_dec_pkg.sv
package smx_dec_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    typedef enum logic [3:0] {
        CLS_ALU     = 4'd0,
        CLS_LOAD    = 4'd1,
        CLS_STORE   = 4'd2,
        CLS_BRANCH  = 4'd3,
        CLS_JUMP    = 4'd4,
        CLS_JREG    = 4'd5,
        CLS_JLINK   = 4'd6,
        CLS_JLREG   = 4'd7,
        CLS_ILLEGAL = 4'd8
    } iclass_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_SLTU
    } alu_fn_e;

    typedef enum logic [2:0] {
        CMP_NONE, CMP_EQ, CMP_NE, CMP_LTZ, CMP_LEZ, CMP_GTZ, CMP_GEZ
    } br_cmp_e;

    typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_sel_e;

    typedef enum logic [1:0] { IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_JABS } imm_kind_e;

    typedef enum logic [1:0] { DST_NONE, DST_RT, DST_RD, DST_LINK } dst_sel_e;

    typedef struct packed {
        iclass_e   cls;
        alu_fn_e   alu_fn;
        br_cmp_e   br_cmp;
        imm_kind_e imm_kind;
        dst_sel_e  dst_sel;
        logic      imm_valid;
        logic      reg_wr;
        logic      mem_op;
        logic      ctrl_xfer;
        wb_sel_e   wb_sel;
    } ctrl_rec_t;

    // primary opcodes
    localparam logic [OPC_W-1:0] OP_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0] OP_ZCMP    = 6'h01;
    localparam logic [OPC_W-1:0] OP_J       = 6'h02;
    localparam logic [OPC_W-1:0] OP_JAL     = 6'h03;
    localparam logic [OPC_W-1:0] OP_BEQ     = 6'h04;
    localparam logic [OPC_W-1:0] OP_BNE     = 6'h05;
    localparam logic [OPC_W-1:0] OP_BLEZ    = 6'h06;
    localparam logic [OPC_W-1:0] OP_BGTZ    = 6'h07;
    localparam logic [OPC_W-1:0] OP_ADDI    = 6'h09;
    localparam logic [OPC_W-1:0] OP_SLTI    = 6'h0A;
    localparam logic [OPC_W-1:0] OP_SLTIU   = 6'h0B;
    localparam logic [OPC_W-1:0] OP_ANDI    = 6'h0C;
    localparam logic [OPC_W-1:0] OP_ORI     = 6'h0D;
    localparam logic [OPC_W-1:0] OP_XORI    = 6'h0E;
    localparam logic [OPC_W-1:0] OP_LOAD    = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE   = 6'h2B;

    // function codes under OP_SPECIAL
    localparam logic [FN_W-1:0] FN_JR   = 6'h08;
    localparam logic [FN_W-1:0] FN_JALR = 6'h09;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h23;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

    // class-level properties, used by the checker
    function automatic logic cls_writes(iclass_e c);
        return c inside {CLS_ALU, CLS_LOAD, CLS_JLINK, CLS_JLREG};
    endfunction

    function automatic logic cls_mem(iclass_e c);
        return c inside {CLS_LOAD, CLS_STORE};
    endfunction

    function automatic logic cls_ctrl(iclass_e c);
        return c inside {CLS_BRANCH, CLS_JUMP, CLS_JREG, CLS_JLINK, CLS_JLREG};
    endfunction

    function automatic ctrl_rec_t quiet_rec();
        ctrl_rec_t r;
        r           = '0;
        r.cls       = CLS_ILLEGAL;
        r.alu_fn    = ALU_ADD;
        r.br_cmp    = CMP_NONE;
        r.imm_kind  = IMM_NONE;
        r.dst_sel   = DST_NONE;
        r.wb_sel    = WB_ALU;
        return r;
    endfunction

endpackage

// File: rtl/smx_op_class.sv
module smx_op_class
    import smx_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [4:0]       rt_fld,
    input  logic [FN_W-1:0]  fn_fld,
    output ctrl_rec_t        rec
);

    function automatic ctrl_rec_t mk_alu(alu_fn_e f, logic use_imm, imm_kind_e k);
        ctrl_rec_t r;
        r           = quiet_rec();
        r.cls       = CLS_ALU;
        r.alu_fn    = f;
        r.imm_valid = use_imm;
        r.imm_kind  = k;
        r.dst_sel   = use_imm ? DST_RT : DST_RD;
        r.reg_wr    = 1'b1;
        return r;
    endfunction

    function automatic ctrl_rec_t mk_mem(logic is_load);
        ctrl_rec_t r;
        r           = quiet_rec();
        r.cls       = is_load ? CLS_LOAD : CLS_STORE;
        r.imm_valid = 1'b1;
        r.imm_kind  = IMM_SEXT;
        r.mem_op    = 1'b1;
        r.dst_sel   = is_load ? DST_RT : DST_NONE;
        r.reg_wr    = is_load;
        r.wb_sel    = is_load ? WB_MEM : WB_ALU;
        return r;
    endfunction

    function automatic ctrl_rec_t mk_branch(br_cmp_e k);
        ctrl_rec_t r;
        r           = quiet_rec();
        r.cls       = CLS_BRANCH;
        r.br_cmp    = k;
        r.imm_kind  = IMM_SEXT;
        r.ctrl_xfer = 1'b1;
        return r;
    endfunction

    function automatic ctrl_rec_t mk_jump(logic absolute, logic link);
        ctrl_rec_t r;
        r           = quiet_rec();
        r.ctrl_xfer = 1'b1;
        r.imm_kind  = absolute ? IMM_JABS : IMM_NONE;
        if (absolute) r.cls = link ? CLS_JLINK : CLS_JUMP;
        else          r.cls = link ? CLS_JLREG : CLS_JREG;
        if (link) begin
            r.reg_wr  = 1'b1;
            r.dst_sel = DST_LINK;
            r.wb_sel  = WB_LINK;
        end
        return r;
    endfunction

    always_comb begin
        rec = quiet_rec();
        unique case (opc)
            OP_SPECIAL: begin
                unique case (fn_fld)
                    FN_ADD:  rec = mk_alu(ALU_ADD,  1'b0, IMM_NONE);
                    FN_SUB:  rec = mk_alu(ALU_SUB,  1'b0, IMM_NONE);
                    FN_AND:  rec = mk_alu(ALU_AND,  1'b0, IMM_NONE);
                    FN_OR:   rec = mk_alu(ALU_OR,   1'b0, IMM_NONE);
                    FN_XOR:  rec = mk_alu(ALU_XOR,  1'b0, IMM_NONE);
                    FN_NOR:  rec = mk_alu(ALU_NOR,  1'b0, IMM_NONE);
                    FN_SLT:  rec = mk_alu(ALU_SLT,  1'b0, IMM_NONE);
                    FN_SLTU: rec = mk_alu(ALU_SLTU, 1'b0, IMM_NONE);
                    FN_JR:   rec = mk_jump(1'b0, 1'b0);
                    FN_JALR: rec = mk_jump(1'b0, 1'b1);
                    default: rec = quiet_rec();
                endcase
            end
            OP_ZCMP: begin
                unique case (rt_fld)
                    5'd0:    rec = mk_branch(CMP_LTZ);
                    5'd1:    rec = mk_branch(CMP_GEZ);
                    default: rec = quiet_rec();
                endcase
            end
            OP_J:      rec = mk_jump(1'b1, 1'b0);
            OP_JAL:    rec = mk_jump(1'b1, 1'b1);
            OP_BEQ:    rec = mk_branch(CMP_EQ);
            OP_BNE:    rec = mk_branch(CMP_NE);
            OP_BLEZ:   rec = mk_branch(CMP_LEZ);
            OP_BGTZ:   rec = mk_branch(CMP_GTZ);
            OP_ADDI:   rec = mk_alu(ALU_ADD,  1'b1, IMM_SEXT);
            OP_SLTI:   rec = mk_alu(ALU_SLT,  1'b1, IMM_SEXT);
            OP_SLTIU:  rec = mk_alu(ALU_SLTU, 1'b1, IMM_SEXT);
            OP_ANDI:   rec = mk_alu(ALU_AND,  1'b1, IMM_ZEXT);
            OP_ORI:    rec = mk_alu(ALU_OR,   1'b1, IMM_ZEXT);
            OP_XORI:   rec = mk_alu(ALU_XOR,  1'b1, IMM_ZEXT);
            OP_LOAD:   rec = mk_mem(1'b1);
            OP_STORE:  rec = mk_mem(1'b0);
            default:   rec = quiet_rec();
        endcase
    end

endmodule

// File: rtl/smx_imm_gen.sv
module smx_imm_gen
    import smx_dec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  imm_kind_e         kind,
    input  logic [25:0]       fld,
    output logic [XLEN-1:0]   imm
);

    localparam int HALF_W = 16;
    localparam int JFLD_W = 26;
    localparam int JSH    = 2;
    localparam int JOUT_W = JFLD_W + JSH;

    always_comb begin
        unique case (kind)
            IMM_SEXT: imm = {{(XLEN-HALF_W){fld[HALF_W-1]}}, fld[HALF_W-1:0]};
            IMM_ZEXT: imm = {{(XLEN-HALF_W){1'b0}}, fld[HALF_W-1:0]};
            IMM_JABS: imm = {{(XLEN-JOUT_W){1'b0}}, fld, {JSH{1'b0}}};
            default:  imm = '0;
        endcase
    end

endmodule

// File: rtl/smx_reg_sel.sv
module smx_reg_sel
    import smx_dec_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  dst_sel_e             sel,
    input  logic [3*REG_W-1:0]   fld,
    output logic [REG_W-1:0]     rs1_idx,
    output logic [REG_W-1:0]     rs2_idx,
    output logic [REG_W-1:0]     rd_idx
);

    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    logic [REG_W-1:0] rd_fld;

    assign rs1_idx = fld[3*REG_W-1:2*REG_W];
    assign rs2_idx = fld[2*REG_W-1:REG_W];
    assign rd_fld  = fld[REG_W-1:0];

    always_comb begin
        unique case (sel)
            DST_RT:   rd_idx = rs2_idx;
            DST_RD:   rd_idx = rd_fld;
            DST_LINK: rd_idx = LINK_IDX;
            default:  rd_idx = '0;
        endcase
    end

endmodule

// File: rtl/smx_decode.sv
module smx_decode
    import smx_dec_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  logic [31:0]       instr,
    output logic [3:0]        iclass,
    output logic [2:0]        alu_fn,
    output logic [2:0]        br_cmp,
    output logic [REG_W-1:0]  rs1_idx,
    output logic [REG_W-1:0]  rs2_idx,
    output logic [REG_W-1:0]  rd_idx,
    output logic [XLEN-1:0]   imm,
    output logic              imm_valid,
    output logic              reg_wr,
    output logic              mem_op,
    output logic              ctrl_xfer,
    output logic [1:0]        wb_sel
);

    ctrl_rec_t rec;

    smx_op_class i_cls (
        .opc    (instr[31:26]),
        .rt_fld (instr[20:16]),
        .fn_fld (instr[5:0]),
        .rec    (rec)
    );

    smx_imm_gen #(.XLEN(XLEN)) i_imm (
        .kind (rec.imm_kind),
        .fld  (instr[25:0]),
        .imm  (imm)
    );

    smx_reg_sel #(.REG_W(REG_W), .LINK_REG(LINK_REG)) i_regs (
        .sel     (rec.dst_sel),
        .fld     (instr[25:11]),
        .rs1_idx (rs1_idx),
        .rs2_idx (rs2_idx),
        .rd_idx  (rd_idx)
    );

    assign iclass    = rec.cls;
    assign alu_fn    = rec.alu_fn;
    assign br_cmp    = rec.br_cmp;
    assign imm_valid = rec.imm_valid;
    assign reg_wr    = rec.reg_wr;
    assign mem_op    = rec.mem_op;
    assign ctrl_xfer = rec.ctrl_xfer;
    assign wb_sel    = rec.wb_sel;

endmodule

// File: rtl/smx_decode_chk.sv
module smx_decode_chk
    import smx_dec_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input logic [3:0]        iclass,
    input logic [2:0]        br_cmp,
    input logic [REG_W-1:0]  rd_idx,
    input logic [XLEN-1:0]   imm,
    input logic              imm_valid,
    input logic              reg_wr,
    input logic              mem_op,
    input logic              ctrl_xfer,
    input logic [1:0]        wb_sel
);

    iclass_e c;
    assign c = iclass_e'(iclass);

    always_comb begin
        if (!$isunknown(iclass)) begin
            p_wr_by_class_r8: assert (reg_wr == cls_writes(c))
                else $error("write flag disagrees with class");
            p_mem_by_class_r9: assert (mem_op == cls_mem(c))
                else $error("memory flag disagrees with class");
            p_ctrl_by_class_r9: assert (ctrl_xfer == cls_ctrl(c))
                else $error("control flag disagrees with class");
            p_link_dest_r4: assert (!(c inside {CLS_JLINK, CLS_JLREG})
                                    || (rd_idx == REG_W'(LINK_REG) && wb_sel == 2'(WB_LINK)))
                else $error("link class without forced destination");
            p_imm_use_r7: assert (!imm_valid || c inside {CLS_ALU, CLS_LOAD, CLS_STORE})
                else $error("immediate operand on wrong class");
            p_cmp_only_branch_r10: assert ((br_cmp != 3'(CMP_NONE)) == (c == CLS_BRANCH))
                else $error("compare kind outside branches");
            p_illegal_quiet_r12: assert (c != CLS_ILLEGAL
                                         || (!reg_wr && !mem_op && !ctrl_xfer && !imm_valid
                                             && imm == '0 && rd_idx == '0))
                else $error("illegal word left side effects");
        end
    end

endmodule

bind smx_decode smx_decode_chk #(
    .XLEN(XLEN), .REG_W(REG_W), .LINK_REG(LINK_REG)
) i_chk (
    .iclass    (iclass),
    .br_cmp    (br_cmp),
    .rd_idx    (rd_idx),
    .imm       (imm),
    .imm_valid (imm_valid),
    .reg_wr    (reg_wr),
    .mem_op    (mem_op),
    .ctrl_xfer (ctrl_xfer),
    .wb_sel    (wb_sel)
);

// File: tb/test_smx_decode.sv
`timescale 1ns/1ps
module test_smx_decode;

    localparam int WDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [31:0] instr = '0;
    logic [3:0]  iclass;
    logic [2:0]  alu_fn, br_cmp;
    logic [4:0]  rs1_idx, rs2_idx, rd_idx;
    logic [31:0] imm;
    logic        imm_valid, reg_wr, mem_op, ctrl_xfer;
    logic [1:0]  wb_sel;

    smx_decode i_smx_decode (
        .instr(instr), .iclass(iclass), .alu_fn(alu_fn), .br_cmp(br_cmp),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx), .imm(imm),
        .imm_valid(imm_valid), .reg_wr(reg_wr), .mem_op(mem_op),
        .ctrl_xfer(ctrl_xfer), .wb_sel(wb_sel)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    int cyc   = 0;

    typedef struct packed {
        logic [3:0]  cls;
        logic [2:0]  alu;
        logic [2:0]  br;
        logic [4:0]  rd;
        logic [31:0] imm;
        logic        iv;
        logic        wr;
        logic        mem;
        logic        ctl;
        logic [1:0]  wb;
    } exp_t;

    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        logic [5:0]  op = w[31:26];
        logic [5:0]  fn = w[5:0];
        logic [31:0] se = {{16{w[15]}}, w[15:0]};
        logic [31:0] ze = {16'h0, w[15:0]};
        e = '0;
        e.cls = 4'd8;
        case (op)
            6'h00: begin
                case (fn)
                    6'h21, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B: begin
                        e.cls = 4'd0;
                        e.rd  = w[15:11];
                        case (fn)
                            6'h23: e.alu = 3'd1;
                            6'h24: e.alu = 3'd2;
                            6'h25: e.alu = 3'd3;
                            6'h26: e.alu = 3'd4;
                            6'h27: e.alu = 3'd5;
                            6'h2A: e.alu = 3'd6;
                            6'h2B: e.alu = 3'd7;
                            default: e.alu = 3'd0;
                        endcase
                    end
                    6'h08: e.cls = 4'd5;
                    6'h09: begin e.cls = 4'd7; e.rd = 5'd31; e.wb = 2'd2; end
                    default: ;
                endcase
            end
            6'h01: begin
                if (w[20:16] == 5'd0)      begin e.cls = 4'd3; e.br = 3'd3; e.imm = se; end
                else if (w[20:16] == 5'd1) begin e.cls = 4'd3; e.br = 3'd6; e.imm = se; end
            end
            6'h02: begin e.cls = 4'd4; e.imm = {4'h0, w[25:0], 2'b00}; end
            6'h03: begin e.cls = 4'd6; e.imm = {4'h0, w[25:0], 2'b00}; e.rd = 5'd31; e.wb = 2'd2; end
            6'h04: begin e.cls = 4'd3; e.br = 3'd1; e.imm = se; end
            6'h05: begin e.cls = 4'd3; e.br = 3'd2; e.imm = se; end
            6'h06: begin e.cls = 4'd3; e.br = 3'd4; e.imm = se; end
            6'h07: begin e.cls = 4'd3; e.br = 3'd5; e.imm = se; end
            6'h09: begin e.cls = 4'd0; e.alu = 3'd0; e.imm = se; e.iv = 1'b1; e.rd = w[20:16]; end
            6'h0A: begin e.cls = 4'd0; e.alu = 3'd6; e.imm = se; e.iv = 1'b1; e.rd = w[20:16]; end
            6'h0B: begin e.cls = 4'd0; e.alu = 3'd7; e.imm = se; e.iv = 1'b1; e.rd = w[20:16]; end
            6'h0C: begin e.cls = 4'd0; e.alu = 3'd2; e.imm = ze; e.iv = 1'b1; e.rd = w[20:16]; end
            6'h0D: begin e.cls = 4'd0; e.alu = 3'd3; e.imm = ze; e.iv = 1'b1; e.rd = w[20:16]; end
            6'h0E: begin e.cls = 4'd0; e.alu = 3'd4; e.imm = ze; e.iv = 1'b1; e.rd = w[20:16]; end
            6'h23: begin e.cls = 4'd1; e.imm = se; e.iv = 1'b1; e.rd = w[20:16]; e.wb = 2'd1; end
            6'h2B: begin e.cls = 4'd2; e.imm = se; e.iv = 1'b1; end
            default: ;
        endcase
        e.wr  = (e.cls == 4'd0) || (e.cls == 4'd1) || (e.cls == 4'd6) || (e.cls == 4'd7);
        e.mem = (e.cls == 4'd1) || (e.cls == 4'd2);
        e.ctl = (e.cls >= 4'd3) && (e.cls <= 4'd7);
        return e;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, instr, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        exp_t e;
        @(posedge clk);
        instr = w;
        @(negedge clk);
        e = model(w);
        chk("R1",  "class",   32'(iclass),    32'(e.cls));
        chk("R2",  "alu_fn",  32'(alu_fn),    32'(e.alu));
        chk("R3",  "rs1",     32'(rs1_idx),   32'(w[25:21]));
        chk("R3",  "rs2",     32'(rs2_idx),   32'(w[20:16]));
        chk("R4",  "rd",      32'(rd_idx),    32'(e.rd));
        if (e.cls == 4'd4 || e.cls == 4'd6 || e.cls == 4'd5 || e.cls == 4'd7)
            chk("R6", "imm",  imm,            e.imm);
        else
            chk("R5", "imm",  imm,            e.imm);
        chk("R7",  "imm_valid", 32'(imm_valid), 32'(e.iv));
        chk("R8",  "reg_wr",  32'(reg_wr),    32'(e.wr));
        chk("R9",  "mem_op",  32'(mem_op),    32'(e.mem));
        chk("R9",  "ctrl",    32'(ctrl_xfer), 32'(e.ctl));
        chk("R10", "br_cmp",  32'(br_cmp),    32'(e.br));
        chk("R11", "wb_sel",  32'(wb_sel),    32'(e.wb));
        if (e.cls == 4'd8)
            chk("R12", "illegal side effects",
                32'({reg_wr, mem_op, ctrl_xfer, imm_valid, wb_sel, alu_fn, br_cmp, rd_idx}) | imm,
                32'd0);
    endtask

    function automatic logic [31:0] rand_word();
        logic [5:0] ops [16] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07,
                                 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h23, 6'h2B};
        logic [5:0] fns [10] = '{6'h21, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B,
                                 6'h08, 6'h09};
        logic [31:0] w = $urandom;
        int sel = int'($urandom % 20);
        if (sel < 16) begin
            w[31:26] = ops[sel];
            if (sel == 0 && ($urandom % 4) != 0) w[5:0] = fns[$urandom % 10];
            if (sel == 1) w[20:16] = 5'($urandom % 3);
        end
        return w;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_CYC && !done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R12: all-zero word is outside the subset
        apply(32'h0000_0000);
        // R2: register ALU, R4 destination from 15:11
        apply({6'h00, 5'd3, 5'd4, 5'd7, 5'd0, 6'h21});
        apply({6'h00, 5'd1, 5'd2, 5'd9, 5'd0, 6'h27});
        // R2 R12: unsupported function
        apply({6'h00, 5'd1, 5'd2, 5'd9, 5'd0, 6'h3F});
        // R5: sign vs zero extension of bit 15
        apply({6'h09, 5'd2, 5'd5, 16'h8000});
        apply({6'h0C, 5'd2, 5'd5, 16'h8000});
        apply({6'h0D, 5'd2, 5'd5, 16'hFFFF});
        // R7 R11: load and store
        apply({6'h23, 5'd8, 5'd10, 16'hFFFC});
        apply({6'h2B, 5'd8, 5'd10, 16'h0004});
        // R10: compare kinds
        apply({6'h04, 5'd1, 5'd2, 16'hFFFF});
        apply({6'h07, 5'd1, 5'd0, 16'h0010});
        apply({6'h01, 5'd1, 5'd0, 16'h0020});
        apply({6'h01, 5'd1, 5'd1, 16'h8001});
        apply({6'h01, 5'd1, 5'd2, 16'h8001});
        // R6: absolute jump immediates
        apply({6'h02, 26'h3FF_FFFF});
        apply({6'h03, 26'h000_0001});
        // R4 R8 R9: link with nonzero 15:11 field
        apply({6'h00, 5'd6, 5'd0, 5'd12, 5'd0, 6'h09});
        apply({6'h00, 5'd6, 5'd0, 5'd12, 5'd0, 6'h08});
        // R1 R12: unknown primary opcode
        apply(32'hFFFF_FFFF);
        for (int i = 0; i < 3000; i++) apply(rand_word());
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule